// File: doc/BRIEF.md
# Write Completion Poller

After a host has sent the final write strobe of a program or erase command to a flash bank, it starts this block. The block then reads one address again and again through a single-outstanding read port until the data shows that the internal operation has finished. Two detection methods are available. The first compares bit 7 of the read word with the value that bit takes once the operation is over. The second watches bit 6 and waits until it stops alternating between consecutive reads.

A status read can coincide with the instant the array finishes, so one hit on the status bits is treated only as a candidate. The block first waits a settle interval, given in clock cycles, so that the whole word has time to become valid. It then issues two confirmation reads. Each of them must still show completion and must also carry the full expected word. If either one fails, the candidate is dropped and polling resumes. A cycle budget set at start bounds the search and ends it with a failure pulse. When completion is confirmed, the block presents the last word it read and returns to idle.

Top module: `pw_write_poller`

## Requirements
- R1: While rst_ni is low and after it is released, busy_o, rd_req_o, done_o and fail_o are all 0.
- R2: The block accepts start_i only while idle. It latches mode, operation, expected word, address and cycle limit, and raises rd_req_o in the next cycle. Every read then uses the latched address. A start_i pulse while busy has no effect.
- R3: With mode_i=0 and erase_i=0 (program), a read is a completion candidate when bit 7 equals bit 7 of the expected word.
- R4: With mode_i=0 and erase_i=1 (erase), a read is a candidate when bit 7 is 1. The target word for an erase is all ones.
- R5: With mode_i=1, a read is a candidate when its bit 6 equals bit 6 of the previous read of the same run. The first read of a run is never a candidate.
- R6: The first confirmation request follows the cycle in which the candidate word was presented by exactly SETTLE_CYC+1 cycles.
- R7: Two confirmation reads follow a candidate, back to back. Each must satisfy the status test of its mode and equal the target word (exp_data_i for a program). On the first one that does not, the candidate is rejected and polling continues with the next read.
- R8: One cycle after the second valid confirmation word arrives, done_o pulses for one cycle, busy_o is 0, and data_o holds that word until the next completion.
- R9: Once timeout_i cycles have passed since start, the next polling read that is not a candidate, or the next rejected confirmation, ends the run. That read returns with no other read outstanding. fail_o then pulses one cycle, the block goes idle, and done_o is not raised for the run.
- R10: At most one read is outstanding: rd_req_o is high for one cycle and is not raised again before rd_valid_i returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (sampled while idle) |
| mode_i | input | 1 | 0: bit-7 data method, 1: bit-6 toggle method |
| erase_i | input | 1 | 0: program, 1: erase |
| exp_data_i | input | DATA_W | Word that was programmed |
| addr_i | input | ADDR_W | Address to poll |
| timeout_i | input | TMO_W | Cycle budget for the polling phase |
| rd_req_o | output | 1 | Read request, one-cycle pulse |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Completion confirmed, one-cycle pulse |
| fail_o | output | 1 | Cycle budget exhausted, one-cycle pulse |
| data_o | output | DATA_W | Last confirmed word |

## Verification
Stimulus covers four kinds of read stream, each with both methods and both operations. A clean stream holds a run of busy words and then the final word. A stream with one planted false hit inside the busy run separates a poller that confirms from one that trusts the first status hit. A stream whose first final word still has wrong low bits shows that the settle wait and the two confirmations decide the outcome, not the first completion sign. A stream that never completes checks the cycle budget. Streams with no busy reads and a second start pulse during a run probe the first-read rule of the toggle method and the latching of the inputs. Read latency varies at random so that the timing of every decision is checked.

// File: rtl/pw_poll_pkg.sv
package pw_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_SETTLE
  } poll_state_e;

  typedef enum logic [1:0] {
    PH_POLL,
    PH_CONF_A,
    PH_CONF_B
  } poll_phase_e;

  localparam logic MODE_DATA7  = 1'b0;
  localparam logic MODE_TOGGLE = 1'b1;
endpackage

// File: rtl/pw_status_eval.sv
module pw_status_eval #(
  parameter int DATA_W  = 16,
  parameter int CMP_BIT = 7,
  parameter int TGL_BIT = 6
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              mode_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic              prev_tgl_i,
  input  logic              have_prev_i,
  output logic              status_ok_o,
  output logic              word_ok_o
);
  import pw_poll_pkg::*;

  logic              final_bit;
  logic [DATA_W-1:0] target;
  logic              data_hit;
  logic              tgl_hit;

  // erased cells read back as ones
  assign final_bit = erase_i ? 1'b1 : exp_i[CMP_BIT];
  assign target    = erase_i ? {DATA_W{1'b1}} : exp_i;
  assign data_hit  = (word_i[CMP_BIT] == final_bit);
  assign tgl_hit   = have_prev_i && (word_i[TGL_BIT] == prev_tgl_i);

  assign status_ok_o = (mode_i == MODE_TOGGLE) ? tgl_hit : data_hit;
  assign word_ok_o   = (word_i == target);
endmodule

// File: rtl/pw_cycle_timer.sv
module pw_cycle_timer #(
  parameter int TMO_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != {TMO_W{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/pw_settle_timer.sv
module pw_settle_timer #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic last_o
);
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;
  localparam logic [SW-1:0] LOAD_VAL = SW'(SETTLE_CYC);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (run_i && (cnt_q > 1)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q <= 1);
endmodule

// File: rtl/pw_write_poller.sv
module pw_write_poller #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 22,
  parameter int TMO_W      = 20,
  parameter int SETTLE_CYC = 8,
  parameter int CMP_BIT    = 7,
  parameter int TGL_BIT    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TMO_W-1:0]  timeout_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [DATA_W-1:0] data_o
);
  import pw_poll_pkg::*;

  localparam bit USE_SETTLE = (SETTLE_CYC > 0);

  poll_state_e       state_q, state_d;
  poll_phase_e       phase_q, phase_d;
  logic              mode_q, erase_q;
  logic [DATA_W-1:0] exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              prev_tgl_q, have_prev_q;
  logic              done_q, fail_q;
  logic [DATA_W-1:0] data_q;

  logic accept, status_ok, word_ok, expired, settle_last;
  logic go_done, go_fail, settle_load;

  assign accept = (state_q == ST_IDLE) && start_i;

  pw_status_eval #(
    .DATA_W (DATA_W),
    .CMP_BIT(CMP_BIT),
    .TGL_BIT(TGL_BIT)
  ) u_eval (
    .word_i     (rd_data_i),
    .mode_i     (mode_q),
    .erase_i    (erase_q),
    .exp_i      (exp_q),
    .prev_tgl_i (prev_tgl_q),
    .have_prev_i(have_prev_q),
    .status_ok_o(status_ok),
    .word_ok_o  (word_ok)
  );

  pw_cycle_timer #(
    .TMO_W(TMO_W)
  ) u_budget (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .run_i    (state_q != ST_IDLE),
    .limit_i  (tmo_q),
    .expired_o(expired)
  );

  pw_settle_timer #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_settle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(settle_load),
    .run_i (state_q == ST_SETTLE),
    .last_o(settle_last)
  );

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    go_done     = 1'b0;
    go_fail     = 1'b0;
    settle_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_REQ;
          phase_d = PH_POLL;
        end
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid_i) begin
          unique case (phase_q)
            PH_POLL: begin
              if (status_ok) begin
                phase_d     = PH_CONF_A;
                settle_load = USE_SETTLE;
                state_d     = USE_SETTLE ? ST_SETTLE : ST_REQ;
              end else if (expired) begin
                go_fail = 1'b1;
                state_d = ST_IDLE;
              end else begin
                state_d = ST_REQ;
              end
            end
            PH_CONF_A, PH_CONF_B: begin
              if (status_ok && word_ok) begin
                if (phase_q == PH_CONF_B) begin
                  go_done = 1'b1;
                  state_d = ST_IDLE;
                  phase_d = PH_POLL;
                end else begin
                  phase_d = PH_CONF_B;
                  state_d = ST_REQ;
                end
              end else begin
                // race with end of operation: drop candidate
                phase_d = PH_POLL;
                if (expired) begin
                  go_fail = 1'b1;
                  state_d = ST_IDLE;
                end else begin
                  state_d = ST_REQ;
                end
              end
            end
            default: phase_d = PH_POLL;
          endcase
        end
      end
      ST_SETTLE: begin
        if (settle_last) state_d = ST_REQ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_POLL;
      mode_q      <= MODE_DATA7;
      erase_q     <= 1'b0;
      exp_q       <= '0;
      addr_q      <= '0;
      tmo_q       <= '0;
      prev_tgl_q  <= 1'b0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      data_q      <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done_q  <= go_done;
      fail_q  <= go_fail;
      if (accept) begin
        mode_q      <= mode_i;
        erase_q     <= erase_i;
        exp_q       <= exp_data_i;
        addr_q      <= addr_i;
        tmo_q       <= timeout_i;
        have_prev_q <= 1'b0;
      end else if ((state_q == ST_WAIT) && rd_valid_i) begin
        prev_tgl_q  <= rd_data_i[TGL_BIT];
        have_prev_q <= 1'b1;
      end
      if (go_done) data_q <= rd_data_i;
    end
  end

  assign rd_req_o  = (state_q == ST_REQ);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign data_o    = data_q;
endmodule

// File: rtl/pw_write_poller_chk.sv
module pw_write_poller_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o
);
  logic              outst_q, busy_d, valid_d;
  logic [ADDR_W-1:0] addr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q <= 1'b0;
      busy_d  <= 1'b0;
      valid_d <= 1'b0;
      addr_d  <= '0;
    end else begin
      if (rd_req_o) outst_q <= 1'b1;
      else if (rd_valid_i) outst_q <= 1'b0;
      busy_d  <= busy_o;
      valid_d <= rd_valid_i;
      addr_d  <= rd_addr_o;
    end
  end

  a_r10_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !outst_q);
  a_r10_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  a_r2_req_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);
  a_r2_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && busy_d) |-> (rd_addr_o == addr_d));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (valid_d && !busy_o));
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  a_r9_fail_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!busy_o && !outst_q));
  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o);
endmodule

bind pw_write_poller pw_write_poller_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .rd_valid_i(rd_valid_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o)
);

// File: tb/tb_pw_write_poller.sv
module tb_pw_write_poller;
  localparam int DW  = 16;
  localparam int AW  = 22;
  localparam int TW  = 20;
  localparam int SET = 8;
  localparam int LOGN = 512;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic          erase_i = 1'b0;
  logic [DW-1:0] exp_data_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [TW-1:0] timeout_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_valid_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          busy_o, done_o, fail_o;
  logic [DW-1:0] data_o;

  always #2 clk_i = ~clk_i;

  pw_write_poller #(.DATA_W(DW), .ADDR_W(AW), .TMO_W(TW), .SETTLE_CYC(SET)) dut (.*);

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  // scenario
  logic          mode_s, erase_s;
  logic [DW-1:0] exp_s, tgt_s;
  int            blen, race_k;
  logic          part_s;
  logic [AW-1:0] case_addr;
  // device / monitor
  int rd_k, nreq, pend, done_n, fail_n, done_c, fail_c, addr_err, ovl_err;
  int req_cyc [LOGN];
  int val_cyc [LOGN];

  function automatic logic [DW-1:0] busy_word(int k);
    logic [DW-1:0] w;
    w    = DW'((k + 1) * 40503) ^ 16'h3c96;
    w[7] = erase_s ? 1'b0 : ~exp_s[7];
    w[6] = k[0];
    return w;
  endfunction

  function automatic logic [DW-1:0] word_at(int k);
    logic [DW-1:0] w, p;
    if (k == race_k) begin
      w    = busy_word(k);
      p    = busy_word(k - 1);
      w[7] = erase_s ? 1'b1 : exp_s[7];
      w[6] = p[6];
      w[0] = ~tgt_s[0];
    end else if (k < blen) begin
      w = busy_word(k);
    end else if (k == blen && part_s) begin
      w = tgt_s ^ 16'h0f0f;
    end else begin
      w = tgt_s;
    end
    return w;
  endfunction

  // transaction-level expectation; returns index of final read or -1
  function automatic int ref_last(output int cand);
    int ph = 0, conf = 0;
    logic havep = 1'b0, p6 = 1'b0, st, wok;
    logic [DW-1:0] w;
    cand = -1;
    for (int k = 0; k < 400; k++) begin
      w   = word_at(k);
      st  = mode_s ? (havep && (w[6] == p6)) : (erase_s ? w[7] : (w[7] == exp_s[7]));
      wok = (w == tgt_s);
      if (ph == 0) begin
        if (st) begin ph = 1; conf = 0; cand = k; end
      end else if (st && wok) begin
        if (conf == 1) return k;
        conf = 1;
      end else begin
        ph = 0;
      end
      p6 = w[6];
      havep = 1'b1;
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // read responder and output monitor
  initial begin
    forever begin
      @(negedge clk_i);
      rd_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_valid_i = 1'b1;
          rd_data_i  = word_at(rd_k);
          if (rd_k < LOGN) val_cyc[rd_k] = cyc;
          rd_k++;
        end
      end
      if (rd_req_o) begin
        if (pend > 0) ovl_err++;
        if (rd_addr_o != case_addr) addr_err++;
        if (nreq < LOGN) req_cyc[nreq] = cyc;
        nreq++;
        pend = 1 + int'($urandom_range(0, 3));
      end
      if (done_o) begin done_n++; done_c = cyc; end
      if (fail_o) begin fail_n++; fail_c = cyc; end
    end
  end

  initial begin
    wait (cyc > 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic run_case(input logic m, input logic e, input logic [DW-1:0] ex, input int bl,
                          input int rk, input logic part, input logic [TW-1:0] tmo, input logic poke);
    int s_cyc, last, cand, w;
    string rq;
    mode_s = m; erase_s = e; exp_s = ex; blen = bl; race_k = rk; part_s = part;
    tgt_s = e ? {DW{1'b1}} : ex;
    rd_k = 0; nreq = 0; pend = 0; done_n = 0; fail_n = 0; addr_err = 0; ovl_err = 0;
    case_addr = AW'($urandom);
    last = ref_last(cand);
    @(negedge clk_i);
    mode_i = m; erase_i = e; exp_data_i = ex; addr_i = case_addr; timeout_i = tmo;
    start_i = 1'b1; s_cyc = cyc;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk_i);
      start_i = 1'b1; addr_i = ~case_addr; mode_i = ~m; erase_i = ~e; exp_data_i = ~ex;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    w = 0;
    while (done_n == 0 && fail_n == 0 && w < 5000) begin @(negedge clk_i); w++; end
    repeat (20) @(negedge clk_i);
    rq = m ? "R5" : (e ? "R4" : "R3");
    chk(req_cyc[0] == s_cyc + 1, "R2", "first request cycle", req_cyc[0] - s_cyc, 1);
    chk(addr_err == 0, "R2", "read address mismatches", addr_err, 0);
    chk(ovl_err == 0, "R10", "overlapping requests", ovl_err, 0);
    chk(busy_o == 1'b0, "R8", "busy after run", int'(busy_o), 0);
    if (last < 0) begin
      chk(fail_n == 1, "R9", "fail pulses", fail_n, 1);
      chk(done_n == 0, "R9", "done pulses on timeout", done_n, 0);
      chk((fail_c - s_cyc >= int'(tmo) + 1) && (fail_c - s_cyc <= int'(tmo) + 8), "R9",
          "fail delay", fail_c - s_cyc, int'(tmo) + 2);
      chk(nreq == rd_k, "R9", "reads left open at fail", nreq, rd_k);
      chk(req_cyc[(nreq - 1) % LOGN] < fail_c, "R9", "request after fail",
          req_cyc[(nreq - 1) % LOGN], fail_c);
    end else begin
      chk(done_n == 1, "R8", "done pulses", done_n, 1);
      chk(fail_n == 0, "R9", "fail pulses", fail_n, 0);
      chk(data_o == tgt_s, "R8", "final word", int'(data_o), int'(tgt_s));
      chk(nreq == last + 1, (rk >= 0 || part) ? "R7" : rq, "read count", nreq, last + 1);
      chk(done_c == val_cyc[last] + 1, "R8", "done cycle", done_c - val_cyc[last], 1);
      chk(req_cyc[cand + 1] - val_cyc[cand] == SET + 1, "R6", "settle gap",
          req_cyc[cand + 1] - val_cyc[cand], SET + 1);
    end
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && rd_req_o == 0 && done_o == 0 && fail_o == 0, "R1", "outputs in reset",
        int'({busy_o, rd_req_o, done_o, fail_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(busy_o == 0 && rd_req_o == 0 && done_o == 0 && fail_o == 0, "R1", "outputs after reset",
        int'({busy_o, rd_req_o, done_o, fail_o}), 0);
    // directed: each method and operation, clean stream
    run_case(1'b0, 1'b0, 16'ha5c3, 3, -1, 1'b0, '1, 1'b0);
    run_case(1'b0, 1'b1, 16'h1234, 4, -1, 1'b0, '1, 1'b0);
    run_case(1'b1, 1'b0, 16'h5a17, 5, -1, 1'b0, '1, 1'b0);
    run_case(1'b1, 1'b1, 16'h0000, 6, -1, 1'b0, '1, 1'b0);
    // planted false hit and partial final word (R7)
    run_case(1'b0, 1'b0, 16'h00ff, 12, 4, 1'b1, '1, 1'b0);
    run_case(1'b1, 1'b0, 16'hbeef, 12, 3, 1'b1, '1, 1'b0);
    run_case(1'b0, 1'b1, 16'h0000, 10, 5, 1'b0, '1, 1'b0);
    // no busy reads: toggle method needs a second read (R5)
    run_case(1'b1, 1'b0, 16'h8001, 0, -1, 1'b0, '1, 1'b0);
    run_case(1'b0, 1'b0, 16'h8001, 0, -1, 1'b0, '1, 1'b0);
    // start while busy is ignored (R2)
    run_case(1'b0, 1'b0, 16'h3c3c, 8, -1, 1'b0, '1, 1'b1);
    // budget exhausted (R9)
    run_case(1'b0, 1'b0, 16'h4242, 100000, -1, 1'b0, TW'(300), 1'b0);
    run_case(1'b1, 1'b1, 16'h4242, 100000, -1, 1'b0, TW'(0), 1'b0);
    for (int i = 0; i < 40; i++) begin
      int bl, rk;
      bl = int'($urandom_range(0, 19));
      rk = (bl >= 6 && $urandom_range(0, 1) == 1) ? 1 + int'($urandom_range(0, bl - 5)) : -1;
      run_case(1'($urandom), 1'($urandom), DW'($urandom), bl, rk, 1'($urandom), '1, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule